// File: doc/BRIEF.md
# Operand Addressing Mode Resolver

This block turns one 6-bit operand field of a 16-bit-word processor into an operand value and a destination that can later be written. One code space covers several kinds of operand: a general register, memory addressed by a register, memory addressed by an extension word plus a register, the three stack forms (pop, peek, push), the stack pointer, the program counter, the overflow register, memory addressed by an extension word, the extension word itself, and short literals. The block reads the eight general registers and the SP, PC and overflow registers from the register file. It reaches a single-port word memory through a request/valid handshake.

The execution stage pulses `start` with a code. It waits for `done` and then reads the value, the destination kind and the cost in extra cycles. The destination stays latched until the next `start`. While the destination is held, one `wr_en` pulse stores a result through the block into that destination. A destination that is a literal takes no write. For an instruction with two operands, the controller resolves operand a first and operand b second, so that extension words are taken from PC and then from PC+1. Fetch of the first instruction word and execution of the opcode are done elsewhere.

Top module: `operand_resolver`

## Requirements
- R1: After reset, `done`, `mem_req`, `mem_we` and all register write strobes are low, and `cost` is 0.
- R2: Codes 0x00-0x07 return the general register indexed by code bits [2:0] (order A,B,C,X,Y,Z,I,J), with `dst_kind`=0 (register) and `dst_reg` equal to that index.
- R3: Codes 0x08-0x0f read memory at the address held in register code[2:0] and return that word, with `dst_kind`=1 (memory) and `dst_addr` equal to the address.
- R4: Codes 0x10-0x17 read an extension word at PC, write PC+1 back, then read memory at (extension word + register code[2:0]) and return it as a memory destination.
- R5: Code 0x18 reads memory at SP and writes SP+1. Code 0x19 reads memory at SP and leaves SP unchanged. Code 0x1a writes SP-1 and reads memory at SP-1. All three are memory destinations.
- R6: Code 0x1b returns SP (`dst_kind`=2), 0x1c returns PC (`dst_kind`=3), and 0x1d returns the overflow register (`dst_kind`=4).
- R7: Code 0x1e reads the extension word at PC, writes PC+1, and returns memory at that word as a memory destination. Code 0x1f returns the extension word itself with `dst_kind`=5 (literal) and writes PC+1.
- R8: Codes 0x20-0x3f return the value code-0x20 with `dst_kind`=5 (literal) and touch neither memory nor any register.
- R9: A `wr_en` pulse while a destination is held stores `wr_data` into that destination: a register, memory through a write request with `mem_we` high, SP, PC or overflow. For a literal destination the write is dropped and nothing changes.
- R10: `cost` is 1 for codes 0x10-0x17, 0x1e and 0x1f, and 0 for every other code.
- R11: Once `mem_req` is raised, it stays high with a stable address and `mem_we` until a cycle with `mem_rvalid`. `done` follows the final memory response by one cycle, whatever the response latency.
- R12: Two operands resolved one after the other take their extension words from consecutive PC values. Operand a is resolved before operand b.
- R13: All address and pointer arithmetic wraps modulo 2^16. A push with SP=0 uses address 0xffff, and PC=0xffff advances to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin resolving `code` (accepted when idle or holding) |
| code | input | 6 | Operand field |
| gpr_rdata | input | 8*W | General registers, register i at bits [i*W +: W] |
| sp_in | input | W | Current stack pointer |
| pc_in | input | W | Current program counter |
| ovf_in | input | W | Current overflow register |
| wr_en | input | 1 | Store `wr_data` into the held destination |
| wr_data | input | W | Result to store |
| mem_req | output | 1 | Memory request, held until `mem_rvalid` |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | W | Memory address |
| mem_wdata | output | W | Memory write data |
| mem_rvalid | input | 1 | Memory response or write acknowledge |
| mem_rdata | input | W | Memory read data |
| gpr_we | output | 1 | General register write strobe |
| gpr_wsel | output | 3 | General register write index |
| gpr_wdata | output | W | General register write data |
| sp_we | output | 1 | SP write strobe |
| sp_wdata | output | W | New SP |
| pc_we | output | 1 | PC write strobe |
| pc_wdata | output | W | New PC |
| ovf_we | output | 1 | Overflow register write strobe |
| ovf_wdata | output | W | New overflow value |
| done | output | 1 | One-cycle pulse: result fields valid |
| value | output | W | Resolved operand value |
| dst_kind | output | 3 | 0 register, 1 memory, 2 SP, 3 PC, 4 overflow, 5 literal |
| dst_reg | output | 3 | Register index for register destinations |
| dst_addr | output | W | Address for memory destinations |
| cost | output | 2 | Extra cycles charged by the mode |

## Verification
All 64 codes are swept three times. Each sweep uses a different register set, and the SP and PC start at positions chosen so that the sweeps together cover ordinary values, the 0x0000/0xffff wrap points and high register contents. This shows whether a fault lies in the register index, the address sum or the direction of the stack adjustment. The memory latency rotates from 0 to 2 cycles across codes, which exposes any capture of data before the response arrives. Write-back is tried on one destination of each kind, including both literal forms, to show that the discard applies only to literals. A fixed two-operand pair and timed single accesses separate correct PC ordering from correct values, and check the stated latency.

// File: rtl/operand_resolver.sv
module operand_resolver #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [5:0]     code,
  input  logic [8*W-1:0] gpr_rdata,
  input  logic [W-1:0]   sp_in,
  input  logic [W-1:0]   pc_in,
  input  logic [W-1:0]   ovf_in,
  input  logic           wr_en,
  input  logic [W-1:0]   wr_data,
  output logic           mem_req,
  output logic           mem_we,
  output logic [W-1:0]   mem_addr,
  output logic [W-1:0]   mem_wdata,
  input  logic           mem_rvalid,
  input  logic [W-1:0]   mem_rdata,
  output logic           gpr_we,
  output logic [2:0]     gpr_wsel,
  output logic [W-1:0]   gpr_wdata,
  output logic           sp_we,
  output logic [W-1:0]   sp_wdata,
  output logic           pc_we,
  output logic [W-1:0]   pc_wdata,
  output logic           ovf_we,
  output logic [W-1:0]   ovf_wdata,
  output logic           done,
  output logic [W-1:0]   value,
  output logic [2:0]     dst_kind,
  output logic [2:0]     dst_reg,
  output logic [W-1:0]   dst_addr,
  output logic [1:0]     cost
);

  typedef enum logic [2:0] {S_IDLE, S_NXT, S_DAT, S_HOLD, S_WR} st_t;

  localparam logic [2:0] K_REG = 3'd0;
  localparam logic [2:0] K_MEM = 3'd1;
  localparam logic [2:0] K_SP  = 3'd2;
  localparam logic [2:0] K_PC  = 3'd3;
  localparam logic [2:0] K_OVF = 3'd4;
  localparam logic [2:0] K_LIT = 3'd5;

  st_t         st;
  logic [5:0]  code_q;
  logic [W-1:0] idx_q;
  logic [W-1:0] wb_q;
  logic [W-1:0] sel_val;
  logic        take;

  assign sel_val   = gpr_rdata[code[2:0]*W +: W];
  assign take      = start && (st == S_IDLE || st == S_HOLD);
  assign gpr_wdata = wb_q;
  assign ovf_wdata = wb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      code_q    <= '0;
      idx_q     <= '0;
      wb_q      <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      gpr_we    <= 1'b0;
      gpr_wsel  <= '0;
      sp_we     <= 1'b0;
      sp_wdata  <= '0;
      pc_we     <= 1'b0;
      pc_wdata  <= '0;
      ovf_we    <= 1'b0;
      done      <= 1'b0;
      value     <= '0;
      dst_kind  <= K_REG;
      dst_reg   <= '0;
      dst_addr  <= '0;
      cost      <= '0;
    end else begin
      done   <= 1'b0;
      gpr_we <= 1'b0;
      sp_we  <= 1'b0;
      pc_we  <= 1'b0;
      ovf_we <= 1'b0;
      case (st)
        S_IDLE, S_HOLD: begin
          if (take) begin
            code_q <= code;
            idx_q  <= sel_val;
            cost   <= 2'd0;
            case (code[5:3])
              3'd0: begin
                value    <= sel_val;
                dst_kind <= K_REG;
                dst_reg  <= code[2:0];
                done     <= 1'b1;
                st       <= S_HOLD;
              end
              3'd1: begin
                mem_req  <= 1'b1;
                mem_we   <= 1'b0;
                mem_addr <= sel_val;
                st       <= S_DAT;
              end
              3'd2: begin
                mem_req  <= 1'b1;
                mem_we   <= 1'b0;
                mem_addr <= pc_in;
                st       <= S_NXT;
              end
              3'd3: begin
                case (code[2:0])
                  3'd0: begin
                    mem_req  <= 1'b1;
                    mem_we   <= 1'b0;
                    mem_addr <= sp_in;
                    sp_we    <= 1'b1;
                    sp_wdata <= sp_in + 1'b1;
                    st       <= S_DAT;
                  end
                  3'd1: begin
                    mem_req  <= 1'b1;
                    mem_we   <= 1'b0;
                    mem_addr <= sp_in;
                    st       <= S_DAT;
                  end
                  3'd2: begin
                    mem_req  <= 1'b1;
                    mem_we   <= 1'b0;
                    mem_addr <= sp_in - 1'b1;
                    sp_we    <= 1'b1;
                    sp_wdata <= sp_in - 1'b1;
                    st       <= S_DAT;
                  end
                  3'd3: begin
                    value    <= sp_in;
                    dst_kind <= K_SP;
                    done     <= 1'b1;
                    st       <= S_HOLD;
                  end
                  3'd4: begin
                    value    <= pc_in;
                    dst_kind <= K_PC;
                    done     <= 1'b1;
                    st       <= S_HOLD;
                  end
                  3'd5: begin
                    value    <= ovf_in;
                    dst_kind <= K_OVF;
                    done     <= 1'b1;
                    st       <= S_HOLD;
                  end
                  default: begin
                    mem_req  <= 1'b1;
                    mem_we   <= 1'b0;
                    mem_addr <= pc_in;
                    st       <= S_NXT;
                  end
                endcase
              end
              default: begin
                value    <= W'(code[4:0]);
                dst_kind <= K_LIT;
                done     <= 1'b1;
                st       <= S_HOLD;
              end
            endcase
          end else if (st == S_HOLD && wr_en) begin
            st <= S_IDLE;
            case (dst_kind)
              K_REG: begin
                gpr_we   <= 1'b1;
                gpr_wsel <= dst_reg;
                wb_q     <= wr_data;
              end
              K_MEM: begin
                mem_req   <= 1'b1;
                mem_we    <= 1'b1;
                mem_addr  <= dst_addr;
                mem_wdata <= wr_data;
                st        <= S_WR;
              end
              K_SP: begin
                sp_we    <= 1'b1;
                sp_wdata <= wr_data;
              end
              K_PC: begin
                pc_we    <= 1'b1;
                pc_wdata <= wr_data;
              end
              K_OVF: begin
                ovf_we <= 1'b1;
                wb_q   <= wr_data;
              end
              default: ;
            endcase
          end
        end
        S_NXT: begin
          if (mem_rvalid) begin
            pc_we    <= 1'b1;
            pc_wdata <= mem_addr + 1'b1;
            cost     <= 2'd1;
            if (code_q == 6'h1f) begin
              mem_req  <= 1'b0;
              value    <= mem_rdata;
              dst_kind <= K_LIT;
              done     <= 1'b1;
              st       <= S_HOLD;
            end else begin
              mem_addr <= (code_q == 6'h1e) ? mem_rdata : mem_rdata + idx_q;
              st       <= S_DAT;
            end
          end
        end
        S_DAT: begin
          if (mem_rvalid) begin
            mem_req  <= 1'b0;
            value    <= mem_rdata;
            dst_kind <= K_MEM;
            dst_addr <= mem_addr;
            done     <= 1'b1;
            st       <= S_HOLD;
          end
        end
        S_WR: begin
          if (mem_rvalid) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module operand_resolver_sva #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         wr_en,
  input logic [2:0]   st,
  input logic [5:0]   code_q,
  input logic         mem_req,
  input logic         mem_we,
  input logic [W-1:0] mem_addr,
  input logic         mem_rvalid,
  input logic         gpr_we,
  input logic         sp_we,
  input logic         pc_we,
  input logic [W-1:0] pc_wdata,
  input logic         ovf_we,
  input logic         done,
  input logic [W-1:0] value,
  input logic [2:0]   dst_kind,
  input logic [1:0]   cost
);

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_lit_discard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3 && wr_en && !start && dst_kind == 3'd5)
      |=> !(gpr_we || sp_we || pc_we || ovf_we || mem_req));

  assert_cost_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cost == ((code_q[5:3] == 3'd2 || code_q == 6'h1e || code_q == 6'h1f) ? 2'd1 : 2'd0)));

  assert_short_literal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && code_q[5]) |-> (dst_kind == 3'd5 && value == W'(code_q[4:0])));

  assert_pc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd1 && mem_rvalid) |=> (pc_we && pc_wdata == W'($past(mem_addr) + 1'b1)));

  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gpr_we, sp_we, pc_we, ovf_we}));

endmodule

bind operand_resolver operand_resolver_sva #(.W(W)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .st(st),
  .code_q(code_q), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_rvalid(mem_rvalid), .gpr_we(gpr_we), .sp_we(sp_we), .pc_we(pc_we),
  .pc_wdata(pc_wdata), .ovf_we(ovf_we), .done(done), .value(value),
  .dst_kind(dst_kind), .cost(cost)
);

// File: tb/operand_resolver_bench.sv
`timescale 1ns/1ps
module operand_resolver_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [5:0] code = '0;
  logic wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] gpr [8];
  logic [W-1:0] sp = '0, pc = '0, ovf = '0;
  logic [8*W-1:0] gpr_rdata;
  logic mem_req, mem_we, mem_rvalid = 1'b0;
  logic [W-1:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic gpr_we, sp_we, pc_we, ovf_we, done;
  logic [2:0] gpr_wsel, dst_kind, dst_reg;
  logic [W-1:0] gpr_wdata, sp_wdata, pc_wdata, ovf_wdata, value, dst_addr;
  logic [1:0] cost;

  int checks = 0, errors = 0, lat_cfg = 0, cnt = 0, wr_cnt = 0;
  logic [W-1:0] wr_addr_seen = '0, wr_data_seen = '0;

  always #2.5 clk = ~clk;

  assign gpr_rdata = {gpr[7], gpr[6], gpr[5], gpr[4], gpr[3], gpr[2], gpr[1], gpr[0]};

  operand_resolver #(.W(W)) u_operand_resolver (
    .clk(clk), .rst_n(rst_n), .start(start), .code(code), .gpr_rdata(gpr_rdata),
    .sp_in(sp), .pc_in(pc), .ovf_in(ovf), .wr_en(wr_en), .wr_data(wr_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .gpr_we(gpr_we), .gpr_wsel(gpr_wsel), .gpr_wdata(gpr_wdata),
    .sp_we(sp_we), .sp_wdata(sp_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata),
    .ovf_we(ovf_we), .ovf_wdata(ovf_wdata), .done(done), .value(value),
    .dst_kind(dst_kind), .dst_reg(dst_reg), .dst_addr(dst_addr), .cost(cost)
  );

  function automatic logic [W-1:0] mfn(input logic [W-1:0] a);
    logic [W-1:0] t;
    t = W'(a * 16'd313 + 16'h02b7);
    return t ^ {a[7:0], a[15:8]};
  endfunction

  always @(posedge clk) begin
    if (pc_we) pc <= pc_wdata;
    if (sp_we) sp <= sp_wdata;
    if (ovf_we) ovf <= ovf_wdata;
    if (gpr_we) gpr[gpr_wsel] <= gpr_wdata;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid = 1'b0;
      cnt = 0;
    end else if (mem_rvalid) begin
      mem_rvalid = 1'b0;
      cnt = 0;
    end else if (mem_req) begin
      if (cnt >= lat_cfg) begin
        mem_rvalid = 1'b1;
        mem_rdata = mfn(mem_addr);
        if (mem_we) begin
          wr_cnt++;
          wr_addr_seen = mem_addr;
          wr_data_seen = mem_wdata;
        end
      end else cnt++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic resolve(input logic [5:0] c, input int lat, output int ncyc);
    logic [W-1:0] ev, ea, w, epc, esp;
    logic [2:0] ek;
    logic [1:0] ec;
    string tag;
    ev = '0; ea = '0; epc = pc; esp = sp; ek = 3'd5; ec = 2'd0;
    if (c < 6'h08) begin
      ev = gpr[c[2:0]]; ek = 3'd0; tag = "R2";
    end else if (c < 6'h10) begin
      ea = gpr[c[2:0]]; ev = mfn(ea); ek = 3'd1; tag = "R3";
    end else if (c < 6'h18) begin
      w = mfn(pc); ea = w + gpr[c[2:0]]; ev = mfn(ea); ek = 3'd1; ec = 2'd1; epc = pc + 1'b1; tag = "R4";
    end else if (c == 6'h18) begin
      ea = sp; esp = sp + 1'b1; ev = mfn(ea); ek = 3'd1; tag = "R5";
    end else if (c == 6'h19) begin
      ea = sp; ev = mfn(ea); ek = 3'd1; tag = "R5";
    end else if (c == 6'h1a) begin
      ea = sp - 1'b1; esp = sp - 1'b1; ev = mfn(ea); ek = 3'd1; tag = "R5";
    end else if (c == 6'h1b) begin
      ev = sp; ek = 3'd2; tag = "R6";
    end else if (c == 6'h1c) begin
      ev = pc; ek = 3'd3; tag = "R6";
    end else if (c == 6'h1d) begin
      ev = ovf; ek = 3'd4; tag = "R6";
    end else if (c == 6'h1e) begin
      w = mfn(pc); ea = w; ev = mfn(w); ek = 3'd1; ec = 2'd1; epc = pc + 1'b1; tag = "R7";
    end else if (c == 6'h1f) begin
      ev = mfn(pc); ek = 3'd5; ec = 2'd1; epc = pc + 1'b1; tag = "R7";
    end else begin
      ev = W'(c - 6'h20); ek = 3'd5; tag = "R8";
    end
    lat_cfg = lat;
    code = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ncyc = 1;
    while (!done && ncyc < 40) begin
      @(negedge clk);
      ncyc++;
    end
    check(done == 1'b1, {tag, " done"}, W'(done), 1);
    check(value == ev, {tag, " value"}, value, ev);
    check(dst_kind == ek, {tag, " kind"}, W'(dst_kind), W'(ek));
    if (ek == 3'd1) check(dst_addr == ea, {tag, " addr"}, dst_addr, ea);
    if (ek == 3'd0) check(dst_reg == c[2:0], {tag, " reg"}, W'(dst_reg), W'(c[2:0]));
    check(cost == ec, "R10 cost", W'(cost), W'(ec));
    @(negedge clk);
    check(pc == epc, {tag, " pc R13"}, pc, epc);
    check(sp == esp, {tag, " sp R13"}, sp, esp);
  endtask

  task automatic write_back(input logic [W-1:0] d);
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic load_set(input int s);
    for (int i = 0; i < 8; i++) begin
      case (s)
        0: gpr[i] = W'(i * 16'h1111 + 1);
        1: gpr[i] = W'(16'hffff - i);
        default: gpr[i] = W'(i << 12);
      endcase
    end
    case (s)
      0: begin sp = 16'h0100; pc = 16'h0040; ovf = 16'h1234; end
      1: begin sp = 16'h0000; pc = 16'hffff; ovf = 16'hfffe; end
      default: begin sp = 16'hfff0; pc = 16'h8000; ovf = 16'h0001; end
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [W-1:0] s_sp, s_pc, s_ovf, s_g3;
    int s_wc;
    for (int i = 0; i < 8; i++) gpr[i] = '0;
    repeat (3) @(negedge clk);
    check(!done && !mem_req && !mem_we && !gpr_we && !sp_we && !pc_we && !ovf_we && cost == 0,
          "R1 reset", W'({done, mem_req, gpr_we, sp_we, pc_we, ovf_we}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !mem_req, "R1 after release", W'({done, mem_req}), 0);

    for (int s = 0; s < 3; s++) begin
      load_set(s);
      @(negedge clk);
      for (int c = 0; c < 64; c++) resolve(6'(c), (c + s) % 3, n);
    end

    load_set(0);
    sp = 16'h0000;
    @(negedge clk);
    resolve(6'h1a, 1, n);
    check(sp == 16'hffff && dst_addr == 16'hffff, "R13 push wrap", dst_addr, 16'hffff);

    pc = 16'h0200;
    @(negedge clk);
    resolve(6'h1f, 0, n);
    check(value == mfn(16'h0200), "R12 operand a word", value, mfn(16'h0200));
    resolve(6'h1e, 1, n);
    check(dst_addr == mfn(16'h0201), "R12 operand b word", dst_addr, mfn(16'h0201));
    check(pc == 16'h0202, "R12 pc after pair", pc, 16'h0202);

    resolve(6'h08, 0, n);
    check(n == 2, "R11 latency 0", W'(n), 2);
    resolve(6'h08, 3, n);
    check(n == 5, "R11 latency 3", W'(n), 5);
    resolve(6'h1f, 2, n);
    check(n == 4, "R11 word latency 2", W'(n), 4);

    resolve(6'h03, 0, n);
    write_back(16'hbeef);
    check(gpr[3] == 16'hbeef, "R9 register write", gpr[3], 16'hbeef);
    resolve(6'h09, 1, n);
    s_wc = wr_cnt;
    write_back(16'h4321);
    check(wr_cnt == s_wc + 1 && wr_addr_seen == gpr[1] && wr_data_seen == 16'h4321,
          "R9 memory write", wr_addr_seen, gpr[1]);
    resolve(6'h1b, 0, n);
    write_back(16'h7000);
    check(sp == 16'h7000, "R9 sp write", sp, 16'h7000);
    resolve(6'h1d, 0, n);
    write_back(16'h00aa);
    check(ovf == 16'h00aa, "R9 overflow write", ovf, 16'h00aa);
    resolve(6'h1c, 0, n);
    write_back(16'h0300);
    check(pc == 16'h0300, "R9 pc write", pc, 16'h0300);

    resolve(6'h25, 0, n);
    s_sp = sp; s_pc = pc; s_ovf = ovf; s_g3 = gpr[3]; s_wc = wr_cnt;
    write_back(16'hdead);
    check(sp == s_sp && pc == s_pc && ovf == s_ovf, "R9 short literal discard", pc, s_pc);
    check(gpr[3] == s_g3 && wr_cnt == s_wc, "R9 short literal no store", W'(wr_cnt), W'(s_wc));
    resolve(6'h1f, 1, n);
    s_sp = sp; s_pc = pc; s_ovf = ovf; s_wc = wr_cnt;
    write_back(16'hdead);
    check(sp == s_sp && pc == s_pc && ovf == s_ovf && wr_cnt == s_wc,
          "R9 word literal discard", pc, s_pc);
    resolve(6'h00, 0, n);
    check(value == gpr[0], "R9 resolver usable after discard", value, gpr[0]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule